// File: doc/BRIEF.md
# Counter-Based Waveform Generator with Shadowed Period and Compare

The block drives one output pin from an up-counter and two software-written values: a period (autoreload) and a compare threshold. Three waveforms are available. A repeating PWM signal runs when the timer is launched with the continuous-start command. A single pulse lasting one period is produced when it is launched with the single-start command. A latching set-once waveform is produced when the set-once mode bit is high. A polarity input inverts the pin at once, including while the timer is disabled.

A preload input selects how period and compare writes land while the timer is running. They either replace the active values on the next clock, or wait in shadow registers until the counter wraps. A one-cycle update flag marks every wrap. While the timer is not running, writes always apply directly.

Top module: `wave_timer`

## Requirements
- R1: After reset the counter is 0, the timer is stopped, `updateFlag` is 0, `waveOut` equals `invertPol`, the active period is all ones and the active compare is 0.
- R2: While running, the counter steps by one each clock from 0 up to the active period, then returns to 0. `updateFlag` is high for exactly the one cycle in which the counter has just wrapped to 0.
- R3: With `setOnceMode` at 0 and a continuous start, the raw output is inactive while count is at or below compare and active while count is above compare. This repeats every period. `waveOut` is the raw level XOR `invertPol`.
- R4: A single start runs exactly one period and stops at the first wrap. The counter then holds at 0 and the output returns to the inactive level.
- R5: With `setOnceMode` at 1, the raw output goes active in the first cycle the count exceeds compare. It stays active through later wraps until `enable` goes low.
- R6: `invertPol` acts combinationally on `waveOut` with no clock edge, including while `enable` is 0.
- R7: With period 1 and compare 0, `waveOut` toggles on every clock, which gives half the clock rate.
- R8: A write with `wrSel`=0 targets the period and `wrSel`=1 targets the compare. While running with `preloadMode`=0, a write becomes the active value on the next clock.
- R9: While running with `preloadMode`=1, a write is held and becomes active at the next wrap, together with any other pending value.
- R10: While the timer is not running, writes become active on the next clock whatever `preloadMode` is.
- R11: Driving `enable` low clears the counter, stops the timer and clears the set-once latch by the next clock, so that `waveOut` equals `invertPol`. Start commands are ignored while `enable` is 0.
- R12: Start commands are ignored while the timer is running. If both start commands arrive together when the timer is stopped, the continuous start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 period, 1 compare |
| wrData | input | CNT_W | Write value |
| enable | input | 1 | Timer enable; low clears and idles |
| startCont | input | 1 | Continuous-start command |
| startSingle | input | 1 | Single-start command |
| setOnceMode | input | 1 | 1 selects the set-once waveform |
| invertPol | input | 1 | Output polarity inversion |
| preloadMode | input | 1 | 1 defers running writes to the next wrap |
| waveOut | output | 1 | Generated waveform |
| updateFlag | output | 1 | One-cycle wrap indication |

## Verification
The bench targets the compare boundary (count equal to compare versus compare+1) and the wrap cycle. A design that is off by one there gives a duty cycle one clock too long or short, or moves the update flag. It changes the compare under both preload settings while the counter is mid-period. A design that ignores preload, or that always defers writes, shows the new threshold one period early or late. It flips polarity with the clock stopped and with the timer disabled, which catches a registered polarity path. It also runs single-shot and set-once sequences: a pulse that repeats, or a latch that releases at a wrap or survives a disable, shows up as a wrong output level.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic loadShadow;
    logic wrImmediate;
  } wg_strobe_t;
endpackage

// File: rtl/wg_datapath.sv
module wg_datapath
  import wg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wg_strobe_t       strobe,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic             atPeriod,
  output logic             pastCmp
);
  localparam logic [CNT_W-1:0] PERIOD_RST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CMP_RST    = '0;

  logic [CNT_W-1:0] cnt, actPeriod, actCmp, shPeriod, shCmp;
  logic             pendPeriod, pendCmp;
  logic             wrPeriod, wrCmp;

  assign wrPeriod = wrEn && !wrSel;
  assign wrCmp    = wrEn && wrSel;
  assign atPeriod = cnt >= actPeriod;
  assign pastCmp  = cnt > actCmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strobe.cntClear) begin
      cnt <= '0;
    end else if (strobe.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actPeriod  <= PERIOD_RST;
      shPeriod   <= PERIOD_RST;
      pendPeriod <= 1'b0;
    end else begin
      if (strobe.loadShadow) begin
        if (pendPeriod) actPeriod <= shPeriod;
        pendPeriod <= 1'b0;
      end
      if (wrPeriod) begin
        shPeriod <= wrData;
        if (strobe.wrImmediate) begin
          actPeriod  <= wrData;
          pendPeriod <= 1'b0;
        end else begin
          pendPeriod <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actCmp  <= CMP_RST;
      shCmp   <= CMP_RST;
      pendCmp <= 1'b0;
    end else begin
      if (strobe.loadShadow) begin
        if (pendCmp) actCmp <= shCmp;
        pendCmp <= 1'b0;
      end
      if (wrCmp) begin
        shCmp <= wrData;
        if (strobe.wrImmediate) begin
          actCmp  <= wrData;
          pendCmp <= 1'b0;
        end else begin
          pendCmp <= 1'b1;
        end
      end
    end
  end

  // R2: a nonzero count is always the previous count plus one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R9: a pending compare value does not reach the active register before a wrap
  p_preload_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pendCmp && !strobe.loadShadow && !wrCmp) |=> $stable(actCmp));
endmodule

// File: rtl/wg_ctrl.sv
module wg_ctrl
  import wg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       startCont,
  input  logic       startSingle,
  input  logic       setOnceMode,
  input  logic       invertPol,
  input  logic       preloadMode,
  input  logic       atPeriod,
  input  logic       pastCmp,
  output wg_strobe_t strobe,
  output logic       waveOut,
  output logic       updateFlag
);
  logic running, singleShot, latched;
  logic wrap, launch;

  assign wrap   = running && atPeriod;
  assign launch = enable && !running && (startCont || startSingle);

  always_comb begin
    strobe.cntClear    = !enable || wrap;
    strobe.cntInc      = running && !atPeriod;
    strobe.loadShadow  = enable && wrap;
    strobe.wrImmediate = !running || !preloadMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      singleShot <= 1'b0;
    end else if (!enable) begin
      running    <= 1'b0;
      singleShot <= 1'b0;
    end else if (launch) begin
      running    <= 1'b1;
      singleShot <= !startCont;
    end else if (wrap && singleShot) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched    <= 1'b0;
      updateFlag <= 1'b0;
    end else begin
      updateFlag <= enable && wrap;
      if (!enable) latched <= 1'b0;
      else if (setOnceMode && running && pastCmp) latched <= 1'b1;
    end
  end

  assign waveOut = ((running && pastCmp) || (setOnceMode && latched)) ^ invertPol;

  // R11: one clock after enable is low the pin sits at the idle level
  p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (waveOut == invertPol));

  // R4: a single-shot run stops at its wrap
  p_single_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && singleShot && atPeriod) |=> !running);

  // R2: the update flag only follows a running cycle
  p_update_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    updateFlag |-> $past(running));

  // R12: an enabled start from idle always launches the timer
  p_start_launch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !running && (startCont || startSingle)) |=> running);
endmodule

// File: rtl/wave_timer.sv
module wave_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             enable,
  input  logic             startCont,
  input  logic             startSingle,
  input  logic             setOnceMode,
  input  logic             invertPol,
  input  logic             preloadMode,
  output logic             waveOut,
  output logic             updateFlag
);
  wg_pkg::wg_strobe_t strobe;
  logic atPeriod, pastCmp;

  wg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .startCont(startCont),
    .startSingle(startSingle), .setOnceMode(setOnceMode), .invertPol(invertPol),
    .preloadMode(preloadMode), .atPeriod(atPeriod), .pastCmp(pastCmp),
    .strobe(strobe), .waveOut(waveOut), .updateFlag(updateFlag)
  );

  wg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .atPeriod(atPeriod), .pastCmp(pastCmp)
  );
endmodule

// File: tb/wave_timer_bench.sv
module wave_timer_bench;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic wrEn = 0, wrSel = 0;
  logic [W-1:0] wrData = '0;
  logic enable = 0, startCont = 0, startSingle = 0;
  logic setOnceMode = 0, invertPol = 0, preloadMode = 0;
  logic waveOut, updateFlag;

  int nRun = 0, nFail = 0;
  string curReq = "R1";

  // reference state
  int m_cnt = 0, m_actP = 65535, m_actC = 0, m_shP = 65535, m_shC = 0;
  bit m_run = 0, m_single = 0, m_latch = 0, m_upd = 0, m_pendP = 0, m_pendC = 0;

  wave_timer #(.CNT_W(W)) u_wave_timer (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .enable(enable), .startCont(startCont), .startSingle(startSingle),
    .setOnceMode(setOnceMode), .invertPol(invertPol), .preloadMode(preloadMode),
    .waveOut(waveOut), .updateFlag(updateFlag)
  );

  always #5 clk = ~clk;

  initial begin
    #1ms;
    nFail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  task automatic check(string req, logic act, logic exp, string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic expWave();
    return ((m_run && m_cnt > m_actC) || (setOnceMode && m_latch)) ^ invertPol;
  endfunction

  task automatic modelStep();
    bit oRun = m_run, imm, wrap;
    int oCnt = m_cnt, oC = m_actC;
    imm = !m_run || !preloadMode;
    wrap = m_run && (m_cnt >= m_actP);
    m_upd = enable && wrap;
    if (!enable) begin
      m_run = 0; m_single = 0; m_cnt = 0; m_latch = 0;
    end else begin
      if (setOnceMode && oRun && oCnt > oC) m_latch = 1;
      if (wrap) begin
        m_cnt = 0;
        if (m_pendP) m_actP = m_shP;
        if (m_pendC) m_actC = m_shC;
        m_pendP = 0; m_pendC = 0;
        if (m_single) m_run = 0;
      end else if (oRun) begin
        m_cnt = m_cnt + 1;
      end else if (startCont || startSingle) begin
        m_run = 1; m_single = !startCont;
      end
    end
    if (wrEn) begin
      if (!wrSel) begin
        m_shP = int'(wrData);
        if (imm) begin m_actP = int'(wrData); m_pendP = 0; end else m_pendP = 1;
      end else begin
        m_shC = int'(wrData);
        if (imm) begin m_actC = int'(wrData); m_pendC = 0; end else m_pendC = 1;
      end
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      check(curReq, waveOut, expWave(), "waveOut");
      check(curReq, updateFlag, m_upd, "updateFlag");
      wrEn = 0; startCont = 0; startSingle = 0;
    end
  endtask

  task automatic wr(bit sel, int val);
    wrEn = 1; wrSel = sel; wrData = W'(val);
    cyc(1);
  endtask

  initial begin
    #23;
    curReq = "R1";
    check("R1", waveOut, 1'b0, "reset waveOut");
    check("R1", updateFlag, 1'b0, "reset updateFlag");
    rst_n = 1;
    @(negedge clk);
    cyc(2);

    // R6: polarity acts without a clock while disabled
    invertPol = 1; #1;
    check("R6", waveOut, 1'b1, "pol while disabled");
    invertPol = 0; #1;
    check("R6", waveOut, 1'b0, "pol back while disabled");

    // R10: writes while stopped apply even with preload on
    curReq = "R10"; preloadMode = 1;
    wr(0, 5); wr(1, 2);
    enable = 1; cyc(1);

    // R3 / R2: continuous PWM, also R12 start while running ignored
    curReq = "R3"; startCont = 1; cyc(14);
    curReq = "R12"; startSingle = 1; cyc(10);
    curReq = "R2"; cyc(6);

    // R8: immediate compare change mid-period
    curReq = "R8"; preloadMode = 0; cyc(2); wr(1, 3); cyc(12);
    // R9: deferred period and compare
    curReq = "R9"; preloadMode = 1; cyc(1); wr(0, 7); wr(1, 1); cyc(20);

    // R11: disable clears
    curReq = "R11"; enable = 0; startCont = 1; cyc(3); enable = 1; cyc(2);

    // R7: fastest waveform
    curReq = "R7"; preloadMode = 0; wr(0, 1); wr(1, 0); startCont = 1; cyc(10);

    // R4: single pulse with both starts → continuous wins first (R12)
    curReq = "R12"; enable = 0; cyc(1); enable = 1;
    wr(0, 4); wr(1, 1); startCont = 1; startSingle = 1; cyc(12);
    curReq = "R4"; enable = 0; cyc(1); enable = 1; startSingle = 1; cyc(15);

    // R5: set-once with polarity flip mid-run
    curReq = "R5"; enable = 0; cyc(1); enable = 1; setOnceMode = 1;
    startCont = 1; cyc(16);
    curReq = "R6"; invertPol = 1; #1;
    check("R6", waveOut, expWave(), "pol flip while running");
    cyc(4);
    curReq = "R11"; enable = 0; cyc(2);
    check("R11", waveOut, invertPol, "idle after set-once disable");
    setOnceMode = 0; cyc(2);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule